// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the architectural register storage of a single-cycle RISC-style processor core. It holds 32 words of 32 bits. Two independent read ports, each addressed by its own 5-bit index, return register contents combinationally, so a decoder can present both source operands in the same cycle it computes their indices. One write port, addressed by a 5-bit index and gated by a write enable, commits its data on the falling clock edge. A result produced in the first half of a cycle is therefore stored at mid-cycle and can be read back during the second half of that same cycle.

Index 0 is a constant-zero register: it has no storage behind it, always reads as zero, and silently drops any write aimed at it. An asynchronous active-low reset clears every stored word to zero.

Top module: `dual_read_regfile`

## Requirements
- R1: While `rst_n` is low every register reads as zero on both ports, and the clear takes effect without waiting for any clock edge.
- R2: When `wr_en` is high, the word at index `wr_idx` takes the value `wr_data` on the falling edge of `clk`; the rising edge commits nothing, so before that falling edge the old value is still read.
- R3: When `wr_en` is low no register changes at the falling edge, whatever `wr_idx` and `wr_data` hold.
- R4: Index 0 always reads as 0x00000000, and a write aimed at index 0 leaves it reading zero.
- R5: Reads are combinational in the read index and the stored contents; a value written at a falling edge is returned in the second half of that same cycle.
- R6: The two read ports are independent: `rd_data_a` reflects `rd_idx_a` and `rd_data_b` reflects `rd_idx_b` for any pair of indices.
- R7: When both read indices are equal, `rd_data_a` and `rd_data_b` carry the same value.
- R8: A write changes only the addressed register; all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| rd_idx_a | input | 5 | Index of read port A |
| rd_data_a | output | 32 | Contents of the register selected by `rd_idx_a` |
| rd_idx_b | input | 5 | Index of read port B |
| rd_data_b | output | 32 | Contents of the register selected by `rd_idx_b` |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the register to write |
| wr_data | input | 32 | Data to write |

## Verification
The write and a read of the same register fall in one cycle: the bench drives a write and points both read ports at the written index just after a rising edge. It samples the ports before the falling edge, where the old value must still appear, and again after the falling edge, where the new value must appear on both ports at once. The same pairing is repeated with index 0 as target, where both samples must be zero, and with the enable low, where neither sample may move.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  parameter int unsigned DEF_NUM_REGS = 32;
  parameter int unsigned DEF_DATA_W   = 32;

  // Index of the hard-wired zero register.
  parameter int unsigned ZERO_REG_IDX = 0;
endpackage

// File: rtl/regfile_wr_decode.sv
module regfile_wr_decode #(
  parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_idx,
  output logic [NUM_REGS-1:0] word_load
);
  always_comb begin
    word_load = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (i != int'(regfile_pkg::ZERO_REG_IDX)) begin
        word_load[i] = wr_en && (wr_idx == ADDR_W'(i));
      end
    end
  end

  // At most one word may load per edge.
  always_comb begin
    AST_LOAD_ONEHOT: assert ($onehot0(word_load)); // R8
  end
endmodule

// File: rtl/regfile_word.sv
module regfile_word #(
  parameter int unsigned DATA_W = regfile_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  AST_WORD_LOADS: assert property (@(negedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R2
  AST_WORD_HOLDS: assert property (@(negedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R3
endmodule

// File: rtl/regfile_read_port.sv
module regfile_read_port #(
  parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = regfile_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
  input  logic [ADDR_W-1:0]               idx,
  output logic [DATA_W-1:0]               data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == ADDR_W'(i)) begin
        data = words[i];
      end
    end
  end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = regfile_pkg::DEF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_idx_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_idx_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [NUM_REGS-1:0]             word_load;
  logic [NUM_REGS-1:0][DATA_W-1:0] word_q;

  regfile_wr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .word_load (word_load)
  );

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      if (g == int'(regfile_pkg::ZERO_REG_IDX)) begin : g_zero
        assign word_q[g] = '0;
      end else begin : g_store
        regfile_word #(
          .DATA_W (DATA_W)
        ) u_word (
          .clk   (clk),
          .rst_n (rst_n),
          .load  (word_load[g]),
          .d     (wr_data),
          .q     (word_q[g])
        );
      end
    end
  endgenerate

  regfile_read_port #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_port_a (
    .words (word_q),
    .idx   (rd_idx_a),
    .data  (rd_data_a)
  );

  regfile_read_port #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_port_b (
    .words (word_q),
    .idx   (rd_idx_b),
    .data  (rd_data_b)
  );

  AST_ZERO_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == '0) |-> (rd_data_a == '0)); // R4
  AST_ZERO_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_b == '0) |-> (rd_data_b == '0)); // R4
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b)); // R7
  AST_WRITE_VISIBLE: assert property (@(negedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != '0) && $stable(rd_idx_a) && (rd_idx_a == wr_idx))
      |=> (rd_data_a == $past(wr_data))); // R5
endmodule

// File: tb/dual_read_regfile_test.sv
module dual_read_regfile_test;
  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_idx_a;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_idx_b;
  logic [31:0] rd_data_b;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int n_checks;
  int n_fails;

  dual_read_regfile uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_a  (rd_idx_a),
    .rd_data_a (rd_data_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(salt) ^ {27'd0, 5'(i)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_both(input logic [4:0] ia, input logic [4:0] ib);
    rd_idx_a = ia;
    rd_idx_b = ib;
    #1;
  endtask

  // Write inside one cycle; both ports watch the target.
  task automatic write_cycle(input logic en, input logic [4:0] idx, input logic [31:0] d,
                             input logic [31:0] before_exp, input logic [31:0] after_exp,
                             input string req);
    @(posedge clk);
    #1;
    wr_en = en; wr_idx = idx; wr_data = d;
    rd_idx_a = idx; rd_idx_b = idx;
    #1;
    check({req, " before falling edge A"}, rd_data_a, before_exp);
    @(negedge clk);
    #1;
    check({req, " after falling edge A"}, rd_data_a, after_exp);
    check({req, " after falling edge B"}, rd_data_b, after_exp);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < 32; i++) begin
      read_both(5'(i), 5'(31 - i));
      check("R1 reset A", rd_data_a, 32'h0);
      check("R1 reset B", rd_data_b, 32'h0);
    end
  endtask

  task automatic t_fill_all;
    for (int i = 1; i < 32; i++) begin
      write_cycle(1'b1, 5'(i), pat(i, 0), 32'h0, pat(i, 0), "R2 R5 fill");
    end
    for (int i = 0; i < 32; i++) begin
      read_both(5'(i), 5'(31 - i));
      check("R6 port A", rd_data_a, (i == 0) ? 32'h0 : pat(i, 0));
      check("R6 port B", rd_data_b, (i == 31) ? 32'h0 : pat(31 - i, 0));
    end
  endtask

  task automatic t_zero_reg;
    write_cycle(1'b1, 5'd0, 32'hFFFF_FFFF, 32'h0, 32'h0, "R4 write to zero");
    read_both(5'd0, 5'd0);
    check("R4 zero A later", rd_data_a, 32'h0);
    check("R7 zero same index", rd_data_b, rd_data_a);
  endtask

  task automatic t_disabled;
    write_cycle(1'b0, 5'd7, 32'h1234_5678, pat(7, 0), pat(7, 0), "R3 disabled");
    write_cycle(1'b0, 5'd31, 32'h0, pat(31, 0), pat(31, 0), "R3 disabled zero data");
  endtask

  task automatic t_isolation;
    write_cycle(1'b1, 5'd12, 32'hDEAD_BEEF, pat(12, 0), 32'hDEAD_BEEF, "R8 overwrite");
    for (int i = 0; i < 32; i++) begin
      read_both(5'(i), 5'(i));
      check("R8 others kept", rd_data_a,
            (i == 0) ? 32'h0 : (i == 12) ? 32'hDEAD_BEEF : pat(i, 0));
      check("R7 same index", rd_data_b, rd_data_a);
    end
  endtask

  task automatic t_back_to_back;
    for (int i = 1; i < 32; i += 5) begin
      write_cycle(1'b1, 5'(i), pat(i, 77), (i == 12) ? 32'hDEAD_BEEF : pat(i, 0),
                  pat(i, 77), "R5 back to back");
    end
  endtask

  task automatic t_async_reset;
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    read_both(5'd1, 5'd26);
    check("R1 async clear A", rd_data_a, 32'h0);
    check("R1 async clear B", rd_data_b, 32'h0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset_state();
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx_a = '0; rd_idx_b = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1'b1;
    t_fill_all();
    t_zero_reg();
    t_disabled();
    t_isolation();
    t_back_to_back();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule